// File: doc/BRIEF.md
# Greyscale Clock Packet and Row Scan Timer

This block drives the timing side of a multiplexed LED matrix built from S-PWM constant-current drivers. While it runs, every scan period starts with a packet of a fixed number of greyscale clock pulses. The packet is followed by a dead gap in which the greyscale clock stays low. The row address moves to the next scan line at a fixed offset inside that gap, so the line drivers settle before the next packet starts.

A host starts the scan with a one-cycle start pulse. To upload new data, it raises a stop request. The timer completes the packet in progress and halts at the end of that packet, never part way through one. It then forces the row address back to line 0, holds the greyscale clock low and raises a stop acknowledge. The acknowledge stays high until the next start. A restart clears the tick counter, and packets begin again from the first tick.

Parameters set the number of pulses in a packet, the pulse length in clock ticks, the gap unit and the number of scan rows.

Top module: `gclk_scan_timer`

## Requirements
- R1: During reset and after its release, gclk_o=0, row_o=0, running_o=0 and stop_ack_o=0.
- R2: A start_i sampled high while the timer is not running sets running_o and clears stop_ack_o at that edge, and it restarts the period at tick 0. gclk_o is high in the first cycle after that edge, and the row is unchanged.
- R3: Each period begins with exactly PKT_PULSES greyscale clock pulses. Each pulse lasts GCLK_TICKS cycles: it is high for the first GCLK_TICKS/2 cycles and low for the rest, and it rises only at a pulse boundary.
- R4: A period lasts PKT_PULSES*GCLK_TICKS + 8*GAP_UNIT cycles, and gclk_o stays low for every cycle after the packet.
- R5: row_o takes its new value in the cycle at tick offset PKT_PULSES*GCLK_TICKS + 2*GAP_UNIT of each period, and at no other time while running.
- R6: row_o advances by one per period and wraps from ROWS-1 to 0.
- R7: A stop request halts the timer at the edge that ends the last pulse of a packet. A request raised during a packet takes effect at the end of that packet. A request raised in the gap is remembered, even after it is withdrawn, and takes effect at the end of the next packet.
- R8: When halted, running_o=0, stop_ack_o=1, gclk_o=0 and row_o=0. These hold until start_i. After a restart, the first row switch moves row_o to 1.
- R9: A start_i received while running has no effect on the pulse, row or period timing.
- R10: A stop request received in the idle state after reset raises stop_ack_o at the next edge, with no packet issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; begins packets from tick 0 |
| stop_req_i | input | 1 | Request to halt at the next packet end |
| gclk_o | output | 1 | Greyscale clock to the LED drivers, registered |
| row_o | output | ROW_W | Scan line address |
| running_o | output | 1 | High while packets are being issued |
| stop_ack_o | output | 1 | High while halted after a stop request |

## Verification
The bench builds the timer with 5 pulses per packet, 4 ticks per pulse, a gap unit of 2 and 3 rows. This gives a 36-cycle period with the row switch at tick 24, so several full periods and a complete row wrap fit into a few hundred cycles. With that small period, the bench can sweep a stop request across every tick offset of a period, covering the packet, the last pulse and the gap. At each offset it compares the halt latency against a closed-form count. Pulse counts, high time, gap silence and the row switch offset are computed arithmetically per period.

// File: rtl/gst_pkg.sv
`timescale 1ns/1ps
package gst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } scan_state_e;

  // Cycles in one full scan period: packet followed by the dead gap.
  function automatic int unsigned period_ticks(int unsigned pulses,
                                               int unsigned per,
                                               int unsigned gap);
    return pulses * per + 8 * gap;
  endfunction

  // Tick offset inside the period at which the new row becomes visible.
  function automatic int unsigned switch_tick(int unsigned pulses,
                                              int unsigned per,
                                              int unsigned gap);
    return pulses * per + 2 * gap;
  endfunction

  // Greyscale clock level for a given tick of the period.
  function automatic logic gclk_level(int unsigned tick,
                                      int unsigned active,
                                      int unsigned per);
    return (tick < active) && ((tick % per) < (per / 2));
  endfunction

  // Next row with wrap to zero.
  function automatic int unsigned row_step(int unsigned row,
                                           int unsigned rows);
    return (row >= rows - 1) ? 0 : row + 1;
  endfunction

endpackage

// File: rtl/gst_ctrl.sv
`timescale 1ns/1ps
module gst_ctrl
  import gst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_req_i,
  input  logic pkt_end_i,
  output logic run_o,
  output logic run_nxt_o,
  output logic go_o,
  output logic halt_o,
  output logic ack_o
);

  scan_state_e state_q, state_d;
  logic        pend_q, pend_d;
  logic        want_stop;

  always_comb begin
    want_stop = pend_q | stop_req_i;
    go_o      = (state_q != ST_RUN) && start_i;
    halt_o    = (state_q == ST_RUN) && pkt_end_i && want_stop;

    state_d = state_q;
    pend_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i)         state_d = ST_RUN;
        else if (stop_req_i) state_d = ST_HALT;
      end
      ST_RUN: begin
        if (halt_o) state_d = ST_HALT;
        else        pend_d  = want_stop;
      end
      ST_HALT: begin
        if (start_i) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign run_nxt_o = (state_d == ST_RUN);
  assign ack_o     = (state_q == ST_HALT);

endmodule

// File: rtl/gst_tick_ctr.sv
`timescale 1ns/1ps
module gst_tick_ctr #(
  parameter int unsigned ACTIVE  = 1104,
  parameter int unsigned PERIOD  = 1360,
  parameter int unsigned SWITCH  = 1168,
  parameter int unsigned TICK_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              clr_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [TICK_W-1:0] tick_nxt_o,
  output logic              pkt_end_o,
  output logic              sw_evt_o
);

  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PERIOD - 1);
  localparam logic [TICK_W-1:0] PKT_LAST  = TICK_W'(ACTIVE - 1);
  localparam logic [TICK_W-1:0] SW_PRE    = TICK_W'(SWITCH - 1);

  logic [TICK_W-1:0] tick_q;

  always_comb begin
    if (clr_i)                   tick_nxt_o = '0;
    else if (!run_i)             tick_nxt_o = tick_q;
    else if (tick_q == LAST_TICK) tick_nxt_o = '0;
    else                         tick_nxt_o = tick_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_nxt_o;
  end

  assign tick_o    = tick_q;
  assign pkt_end_o = run_i && (tick_q == PKT_LAST);
  assign sw_evt_o  = run_i && !clr_i && (tick_q == SW_PRE);

endmodule

// File: rtl/gst_gclk_gen.sv
`timescale 1ns/1ps
module gst_gclk_gen
  import gst_pkg::*;
#(
  parameter int unsigned ACTIVE = 1104,
  parameter int unsigned PER    = 8,
  parameter int unsigned TICK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_nxt_i,
  input  logic [TICK_W-1:0] tick_nxt_i,
  output logic              gclk_o
);

  logic gclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gclk_q <= 1'b0;
    else        gclk_q <= run_nxt_i && gclk_level(32'(tick_nxt_i), ACTIVE, PER);
  end

  assign gclk_o = gclk_q;

endmodule

// File: rtl/gst_row_sel.sv
`timescale 1ns/1ps
module gst_row_sel
  import gst_pkg::*;
#(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  logic             sw_evt_i,
  output logic [ROW_W-1:0] row_o
);

  generate
    if (ROWS > 1) begin : g_multi
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
        if (!rst_n || halt_i) row_q <= '0;
        else if (sw_evt_i)    row_q <= ROW_W'(row_step(32'(row_q), ROWS));
      end
      assign row_o = row_q;
    end else begin : g_single
      assign row_o = '0;
    end
  endgenerate

endmodule

// File: rtl/gclk_scan_timer.sv
`timescale 1ns/1ps
module gclk_scan_timer
  import gst_pkg::*;
#(
  parameter  int unsigned PKT_PULSES = 138,
  parameter  int unsigned GCLK_TICKS = 8,
  parameter  int unsigned GAP_UNIT   = 32,
  parameter  int unsigned ROWS       = 32,
  localparam int unsigned ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_req_i,
  output logic             gclk_o,
  output logic [ROW_W-1:0] row_o,
  output logic             running_o,
  output logic             stop_ack_o
);

  localparam int unsigned ACTIVE = PKT_PULSES * GCLK_TICKS;
  localparam int unsigned PERIOD = period_ticks(PKT_PULSES, GCLK_TICKS, GAP_UNIT);
  localparam int unsigned SWITCH = switch_tick(PKT_PULSES, GCLK_TICKS, GAP_UNIT);
  localparam int unsigned TICK_W = $clog2(PERIOD);

  // Named internal events, also observed by the bound checker.
  logic              run_w, run_nxt_w, go_w, halt_w;
  logic              pkt_end_w, sw_evt_w;
  logic [TICK_W-1:0] tick_q_w, tick_nxt_w;

  gst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_req_i (stop_req_i),
    .pkt_end_i  (pkt_end_w),
    .run_o      (run_w),
    .run_nxt_o  (run_nxt_w),
    .go_o       (go_w),
    .halt_o     (halt_w),
    .ack_o      (stop_ack_o)
  );

  gst_tick_ctr #(
    .ACTIVE (ACTIVE),
    .PERIOD (PERIOD),
    .SWITCH (SWITCH),
    .TICK_W (TICK_W)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_w),
    .clr_i      (go_w | halt_w),
    .tick_o     (tick_q_w),
    .tick_nxt_o (tick_nxt_w),
    .pkt_end_o  (pkt_end_w),
    .sw_evt_o   (sw_evt_w)
  );

  gst_gclk_gen #(
    .ACTIVE (ACTIVE),
    .PER    (GCLK_TICKS),
    .TICK_W (TICK_W)
  ) u_gclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_nxt_i  (run_nxt_w),
    .tick_nxt_i (tick_nxt_w),
    .gclk_o     (gclk_o)
  );

  gst_row_sel #(
    .ROWS  (ROWS),
    .ROW_W (ROW_W)
  ) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_i   (halt_w),
    .sw_evt_i (sw_evt_w),
    .row_o    (row_o)
  );

  assign running_o = run_w;

endmodule

// File: rtl/gst_chk.sv
`timescale 1ns/1ps
module gst_chk #(
  parameter int unsigned ACTIVE = 1104,
  parameter int unsigned PER    = 8,
  parameter int unsigned ROWS   = 32,
  parameter int unsigned TICK_W = 11,
  parameter int unsigned ROW_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gclk_o,
  input logic              running_o,
  input logic              stop_ack_o,
  input logic              pkt_end_w,
  input logic              sw_evt_w,
  input logic [TICK_W-1:0] tick_w,
  input logic [ROW_W-1:0]  row_o
);

  // R3
  gclk_rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gclk_o) |-> ((32'(tick_w) % PER) == 0));

  // R4
  gclk_gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gclk_o |-> (32'(tick_w) < ACTIVE));

  // R5
  row_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_o) |-> ($past(sw_evt_w) || stop_ack_o));

  // R6
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_o) < ROWS);

  // R7
  halt_at_pkt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_ack_o) && $past(running_o)) |-> $past(pkt_end_w));

  // R8
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack_o |-> (!running_o && !gclk_o));

  // R8
  stopped_gclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !gclk_o);

endmodule

bind gclk_scan_timer gst_chk #(
  .ACTIVE (ACTIVE),
  .PER    (GCLK_TICKS),
  .ROWS   (ROWS),
  .TICK_W (TICK_W),
  .ROW_W  (ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gclk_o     (gclk_o),
  .running_o  (running_o),
  .stop_ack_o (stop_ack_o),
  .pkt_end_w  (pkt_end_w),
  .sw_evt_w   (sw_evt_w),
  .tick_w     (tick_q_w),
  .row_o      (row_o)
);

// File: tb/gclk_scan_timer_tb.sv
`timescale 1ns/1ps
module gclk_scan_timer_tb;

  localparam int PKT  = 5;
  localparam int PER  = 4;
  localparam int GAP  = 2;
  localparam int ROWS = 3;
  localparam int ACT  = PKT * PER;
  localparam int RT   = ACT + 8 * GAP;
  localparam int SW   = ACT + 2 * GAP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_req_i = 1'b0;
  logic       gclk_o, running_o, stop_ack_o;
  logic [1:0] row_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // Bench reference state
  bit m_run = 0, m_ack = 0, m_pend = 0;
  int m_k = 0, m_row = 0;

  always #2.5 clk = ~clk;

  gclk_scan_timer #(
    .PKT_PULSES (PKT),
    .GCLK_TICKS (PER),
    .GAP_UNIT   (GAP),
    .ROWS       (ROWS)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_req_i (stop_req_i),
    .gclk_o     (gclk_o),
    .row_o      (row_o),
    .running_o  (running_o),
    .stop_ack_o (stop_ack_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive inputs for one edge, advance the reference, sample at the next negedge.
  task automatic step(input bit st, input bit sp);
    bit exp_g;
    start_i    = st;
    stop_req_i = sp;
    if (m_run) begin
      if (m_k == ACT - 1 && (m_pend || sp)) begin
        m_run = 0; m_ack = 1; m_row = 0; m_k = 0; m_pend = 0;
      end else begin
        m_pend = m_pend || sp;
        m_k = (m_k + 1) % RT;
        if (m_k == SW) m_row = (m_row + 1) % ROWS;
      end
    end else if (st) begin
      m_run = 1; m_ack = 0; m_k = 0; m_pend = 0;
    end else if (sp) begin
      m_ack = 1;
    end
    @(negedge clk);
    exp_g = m_run && (m_k < ACT) && ((m_k % PER) < PER / 2);
    chk(gclk_o == exp_g, (m_k < ACT) ? "R3 gclk" : "R4 gclk", int'(gclk_o), int'(exp_g));
    chk(int'(row_o) == m_row, "R5 row", int'(row_o), m_row);
    chk(running_o == m_run, "R7 running", int'(running_o), int'(m_run));
    chk(stop_ack_o == m_ack, "R8 ack", int'(stop_ack_o), int'(m_ack));
  endtask

  initial begin
    int hi, gap_hi, rises, wraps, prev_row, n, exp_n;
    bit prev_g;

    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk(gclk_o == 0 && running_o == 0 && stop_ack_o == 0 && row_o == 0,
        "R1 in reset", int'({gclk_o, running_o, stop_ack_o}), 0);
    rst_n = 1'b1;
    step(0, 0);
    step(0, 0);
    chk(gclk_o == 0 && running_o == 0 && stop_ack_o == 0 && row_o == 0,
        "R1 after release", int'({gclk_o, running_o, stop_ack_o}), 0);

    // R10: stop while idle
    step(0, 1);
    chk(stop_ack_o == 1, "R10 idle stop ack", int'(stop_ack_o), 1);
    chk(gclk_o == 0, "R10 no pulse", int'(gclk_o), 0);
    step(0, 0);
    chk(stop_ack_o == 1, "R8 ack held", int'(stop_ack_o), 1);

    // R2: start
    step(1, 0);
    chk(running_o == 1 && stop_ack_o == 0, "R2 running", int'({running_o, stop_ack_o}), 2);
    chk(gclk_o == 1, "R2 first pulse", int'(gclk_o), 1);
    chk(row_o == 0, "R2 row", int'(row_o), 0);

    // Four full periods: pulse counts, gap silence, row switch offset and wrap
    wraps = 0;
    prev_g = 0;
    for (int p = 0; p < 4; p++) begin
      hi = 0; gap_hi = 0; rises = 0;
      for (int c = 0; c < RT; c++) begin
        if (gclk_o) hi++;
        if (gclk_o && c >= ACT) gap_hi++;
        if (gclk_o && !prev_g) rises++;
        prev_g = gclk_o;
        prev_row = int'(row_o);
        // R9: start mid-run is ignored
        step((p == 2 && c == 3) ? 1'b1 : 1'b0, 1'b0);
        if (int'(row_o) != prev_row) begin
          chk(((c + 1) % RT) == SW, "R5 switch offset", (c + 1) % RT, SW);
          chk(int'(row_o) == (prev_row + 1) % ROWS, "R6 row step", int'(row_o), (prev_row + 1) % ROWS);
          if (prev_row == ROWS - 1) wraps++;
        end
      end
      chk(rises == PKT, "R3 pulses per packet", rises, PKT);
      chk(hi == PKT * (PER / 2), "R3 high cycles", hi, PKT * (PER / 2));
      chk(gap_hi == 0, "R4 gap silent", gap_hi, 0);
    end
    chk(wraps == 1, "R6 wrap count", wraps, 1);
    chk(int'(row_o) == 1, "R9 row after ignored start", int'(row_o), 1);

    // R7/R8: stop request at every tick offset of a period
    for (int t = 0; t < RT; t++) begin
      if (!m_run) step(1, 0);
      while (m_k != t) step(0, 0);
      n = 0;
      do begin
        step(0, 1);
        n++;
      end while (!stop_ack_o && n < 3 * RT);
      exp_n = (t <= ACT - 1) ? (ACT - t) : (RT - t + ACT);
      chk(n == exp_n, "R7 halt latency", n, exp_n);
      chk(row_o == 0, "R8 row forced", int'(row_o), 0);
      chk(gclk_o == 0 && running_o == 0, "R8 quiet", int'({gclk_o, running_o}), 0);
      step(0, 0);
      chk(stop_ack_o == 1, "R8 ack held", int'(stop_ack_o), 1);
    end

    // R7: short request in the gap is remembered
    step(1, 0);
    while (m_k != ACT + 1) step(0, 0);
    step(0, 1);
    n = 1;
    while (!stop_ack_o && n < 3 * RT) begin
      step(0, 0);
      n++;
    end
    chk(n == RT - (ACT + 1) + ACT, "R7 latched gap request", n, RT - (ACT + 1) + ACT);

    // R8: restart, first switch lands on row 1
    step(1, 0);
    chk(row_o == 0 && running_o == 1, "R8 restart row", int'(row_o), 0);
    repeat (SW) step(0, 0);
    chk(row_o == 1, "R8 first switch after restart", int'(row_o), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule